// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a synchronous request port and an asynchronous 8K x 8 static RAM. A client raises a one-cycle request carrying a direction, a 13-bit address and (for writes) a byte. The controller latches these on acceptance and plays out a fixed pin sequence. The sequence drives an active-low select, an active-high select, a write strobe and an output enable. It also drives a split data path made of an outgoing byte, an incoming byte and a drive-enable for the external tri-state pins. All timing is counted in system-clock cycles derived from parameters (clock period and the RAM's minimum pulse and setup times). The defaults give 7 read cycles and a 1 + 5 + 1 write at 100 MHz.

For a read, the RAM is held selected with output enable asserted for the whole access. The incoming byte is sampled on the last cycle and handed back with a single-cycle valid pulse. For a write, the selects come up with the data already driven. The write strobe is then held low for the pulse count and released. Selection and data are kept for one more recovery cycle, and then everything returns to idle. Only one transaction is in flight, and requests seen while busy are dropped.

Top module: `sram_if_ctrl`

## Requirements
- R1: After reset, the active-low select is 1, the active-high select is 0, the write strobe is 1, the output enable is 1, the data drive-enable is 0, and busy and rd_valid are 0.
- R2: The two select pins always indicate the same state: the active-low select is 0 exactly when the active-high select is 1.
- R3: An accepted read keeps both selects active, the write strobe high and the output enable low for exactly 7 cycles, with no data drive. In the cycle after, rd_valid is 1 for one cycle and rd_data holds the byte present on mem_dq_i during the seventh cycle.
- R4: An accepted write gives 1 setup cycle (selected, strobe high, data driven), then exactly 5 cycles of strobe low, then 1 recovery cycle (selected, strobe high, data driven), and then idle. The output enable stays high throughout.
- R5: The address and the outgoing byte do not change during a cycle where the write strobe is low, nor while the selects stay active.
- R6: The data drive-enable is 1 only while the selects are active and the output enable is high.
- R7: busy is 1 from the cycle after acceptance until the transaction finishes. A request raised while busy is ignored and touches no memory location.
- R8: Address and write byte are captured on acceptance. Changing req_addr or req_wdata afterwards does not affect the transaction in progress.
- R9: When a read directly follows a write, the data drive is already 0 in the cycle before the output enable first goes low.
- R10: A request is accepted in any cycle where busy is 0, so a new transaction may begin one cycle after the previous one completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe, taken when busy is 0 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transaction in progress |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 8 | Captured read byte |
| mem_addr | output | 13 | RAM address pins |
| mem_cs_n | output | 1 | Active-low RAM select |
| mem_cs | output | 1 | Active-high RAM select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | 8 | Byte driven toward the RAM |
| mem_dq_oe | output | 1 | Drive-enable for the data pins |
| mem_dq_i | input | 8 | Byte read from the RAM pins |

## Verification
Pin states are compared cycle by cycle against the expected sequence for reads and writes at the lowest and highest addresses, with all-zero, all-one and alternating bytes. This shows whether the strobe length, the setup and recovery phases, and the address decoding are right. The bench memory returns a poison byte until the read has been held for the full count, so a read that is too short or samples on the wrong cycle returns wrong data. Scrambling the request inputs after acceptance, and raising a write request in the middle of a read, separates capture-on-accept and drop-while-busy from pass-through behaviour. A write followed at once by a read exposes any overlap between the data drive and the output enable.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the static RAM strobe controller.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_READ    = 3'd1,
        PH_WSETUP  = 3'd2,
        PH_WSTROBE = 3'd3,
        PH_WRECOV  = 3'd4
    } phase_e;

    // Rounds a time up to a whole number of clock cycles.
    function automatic int cyc_ceil(input int t_ns, input int clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq.sv
// Phase sequencer: walks idle -> read, or idle -> write setup -> strobe
// -> recovery, and holds each phase for its parameter cycle count.
// Assumes every count is at least 1.
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC  = 7,
    parameter int SU_CYC  = 1,
    parameter int STB_CYC = 5,
    parameter int REC_CYC = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    input  logic   req_we,
    output phase_e phase_q,
    output phase_e phase_d,
    output logic   accept,
    output logic   rd_last
);
    localparam int MAXLEN = imax(imax(RD_CYC, SU_CYC), imax(STB_CYC, REC_CYC));
    localparam int CNT_W  = $clog2(MAXLEN + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cur_len;
    logic             last;

    // Length of the phase currently active.
    always_comb begin
        case (phase_q)
            PH_READ:    cur_len = CNT_W'(RD_CYC);
            PH_WSETUP:  cur_len = CNT_W'(SU_CYC);
            PH_WSTROBE: cur_len = CNT_W'(STB_CYC);
            PH_WRECOV:  cur_len = CNT_W'(REC_CYC);
            default:    cur_len = CNT_W'(1);
        endcase
    end

    assign last    = (cnt_q == cur_len - CNT_W'(1));
    assign accept  = req && (phase_q == PH_IDLE);
    assign rd_last = (phase_q == PH_READ) && last;

    // Next phase selection.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:    if (accept) phase_d = req_we ? PH_WSETUP : PH_READ;
            PH_READ:    if (last)   phase_d = PH_IDLE;
            PH_WSETUP:  if (last)   phase_d = PH_WSTROBE;
            PH_WSTROBE: if (last)   phase_d = PH_WRECOV;
            PH_WRECOV:  if (last)   phase_d = PH_IDLE;
            default:                phase_d = PH_IDLE;
        endcase
    end

    // Phase register and in-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if (phase_d != phase_q || phase_q == PH_IDLE)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/sram_pin_drv.sv
// Pin driver: registers every RAM-side pin from the next phase so that
// the pins come straight from flops. Latches address and write byte
// when a request is accepted and holds them until the next acceptance.
module sram_pin_drv
    import sram_ctrl_pkg::*;
#(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase_d,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_cs,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe
);
    logic sel_d, we_d, oe_d, drv_d;

    // Decode of the pin levels wanted in the next cycle.
    always_comb begin
        sel_d = (phase_d != PH_IDLE);
        we_d  = (phase_d == PH_WSTROBE);
        oe_d  = (phase_d == PH_READ);
        drv_d = (phase_d == PH_WSETUP) || (phase_d == PH_WSTROBE) ||
                (phase_d == PH_WRECOV);
    end

    // Strobe and select flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs_n  <= 1'b1;
            mem_cs    <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_cs_n  <= ~sel_d;
            mem_cs    <= sel_d;
            mem_we_n  <= ~we_d;
            mem_oe_n  <= ~oe_d;
            mem_dq_oe <= drv_d;
        end
    end

    // Address and write byte captured on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_dq_o <= req_wdata;
        end
    end

endmodule

// File: rtl/sram_rd_capture.sv
// Read capture: samples the RAM data pins on the final read cycle and
// raises a one-cycle valid with the sampled byte.
module sram_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_last,
    input  logic [DW-1:0] mem_dq_i,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    // Capture register and valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_last;
            if (rd_last) rd_data <= mem_dq_i;
        end
    end

endmodule

// File: rtl/sram_if_ctrl.sv
// Top of the static RAM strobe controller. Converts single-word requests
// into select / strobe / enable sequences whose lengths come from the
// clock period and the RAM's minimum timings. Assumes one request at a
// time; requests seen while busy are dropped.
module sram_if_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW        = 13,
    parameter int DW        = 8,
    parameter int CLK_NS    = 10,
    parameter int T_RC_NS   = 70,
    parameter int T_WC_NS   = 70,
    parameter int T_WP_NS   = 50,
    parameter int T_AW_NS   = 60,
    parameter int T_DS_NS   = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_cs,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);
    localparam int RD_CYC  = imax(1, cyc_ceil(T_RC_NS, CLK_NS));
    localparam int STB_CYC = imax(1, imax(cyc_ceil(T_WP_NS, CLK_NS),
                                          cyc_ceil(T_DS_NS, CLK_NS)));
    localparam int SU_CYC  = imax(1, cyc_ceil(T_AW_NS, CLK_NS) - STB_CYC);
    localparam int REC_CYC = imax(1, cyc_ceil(T_WC_NS, CLK_NS) - SU_CYC - STB_CYC);

    phase_e phase_q, phase_d;
    logic   accept, rd_last;

    sram_seq #(
        .RD_CYC (RD_CYC),
        .SU_CYC (SU_CYC),
        .STB_CYC(STB_CYC),
        .REC_CYC(REC_CYC)
    ) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .req_we (req_we),
        .phase_q(phase_q),
        .phase_d(phase_d),
        .accept (accept),
        .rd_last(rd_last)
    );

    sram_pin_drv #(.AW(AW), .DW(DW)) pins_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_d  (phase_d),
        .accept   (accept),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .mem_addr (mem_addr),
        .mem_cs_n (mem_cs_n),
        .mem_cs   (mem_cs),
        .mem_we_n (mem_we_n),
        .mem_oe_n (mem_oe_n),
        .mem_dq_o (mem_dq_o),
        .mem_dq_oe(mem_dq_oe)
    );

    sram_rd_capture #(.DW(DW)) cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_last (rd_last),
        .mem_dq_i(mem_dq_i),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );

    assign busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/sram_if_ctrl_chk.sv
// Property checker for the strobe controller, bound to every instance.
// Watches only the ports; the strobe width is measured with a counter.
module sram_if_ctrl_chk #(
    parameter int AW      = 13,
    parameter int DW      = 8,
    parameter int STB_CYC = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic          busy,
    input logic          rd_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_cs_n,
    input logic          mem_cs,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic [DW-1:0] mem_dq_o,
    input logic          mem_dq_oe
);
    localparam int CW = $clog2(STB_CYC + 2) + 1;
    logic [CW-1:0] low_cnt;

    // Counts consecutive cycles with the write strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n)         low_cnt <= '0;
        else if (!mem_we_n) low_cnt <= low_cnt + CW'(1);
        else                low_cnt <= '0;
    end

    assert_sel_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n == !mem_cs);

    assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> low_cnt == CW'(STB_CYC));

    assert_strobe_needs_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));

    assert_addr_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    assert_wdata_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_o));

    assert_drive_rules_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_cs_n));

    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_busy_on_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);

    assert_release_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (!mem_dq_oe && !$past(mem_dq_oe)));

endmodule

bind sram_if_ctrl sram_if_ctrl_chk #(.AW(AW), .DW(DW), .STB_CYC(STB_CYC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .busy     (busy),
    .rd_valid (rd_valid),
    .mem_addr (mem_addr),
    .mem_cs_n (mem_cs_n),
    .mem_cs   (mem_cs),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_dq_o (mem_dq_o),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_if_ctrl_tb_top.sv
// Directed bench for the strobe controller with a behavioural RAM that
// returns a poison byte until a read has been held for the full count.
module sram_if_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RD_N  = 7;
    localparam int STB_N = 5;
    localparam logic [7:0] POISON = 8'hEE;
    // Pin vector {cs_n, cs, we_n, oe_n, dq_oe, busy}
    localparam logic [5:0] P_IDLE = 6'b101100;
    localparam logic [5:0] P_RD   = 6'b011001;
    localparam logic [5:0] P_WHI  = 6'b011111;
    localparam logic [5:0] P_WLO  = 6'b010111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, rd_valid;
    logic [7:0]  rd_data;
    logic [12:0] mem_addr;
    logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_o, mem_dq_i;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_if_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    // Behavioural RAM
    logic [7:0] mem [int];
    int         rd_age = 0;
    logic [7:0] wr_hold = '0;
    logic       wr_pend = 1'b0;
    wire        selected = !mem_cs_n && mem_cs;
    wire        rd_on = selected && mem_we_n && !mem_oe_n;

    function automatic logic [7:0] peek(input logic [12:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 8'h00;
    endfunction

    always @(*) mem_dq_i = (rd_on && rd_age >= RD_N - 1) ? peek(mem_addr) : POISON;

    always @(posedge clk) begin
        rd_age <= rd_on ? rd_age + 1 : 0;
        if (selected && !mem_we_n && mem_dq_oe) begin
            wr_hold <= mem_dq_o;
            wr_pend <= 1'b1;
        end else if (wr_pend) begin
            mem[int'(mem_addr)] = wr_hold;
            wr_pend <= 1'b0;
        end
    end

    function automatic logic [5:0] pins();
        return {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe, busy};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive a request at a falling edge; scramble inputs after acceptance (R8).
    task automatic issue(input logic we, input logic [12:0] a, input logic [7:0] d);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0; req_addr = ~a; req_wdata = ~d; req_we = ~we;
    endtask

    task automatic do_write(input logic [12:0] a, input logic [7:0] d);
        issue(1'b1, a, d);
        chk("R4 setup pins", pins(), P_WHI);
        chk("R8 write addr", mem_addr, a);
        chk("R8 write byte", mem_dq_o, d);
        @(negedge clk);
        for (int i = 0; i < STB_N; i++) begin
            chk("R4 strobe pins", pins(), P_WLO);
            chk("R5 addr held", mem_addr, a);
            @(negedge clk);
        end
        chk("R4 recovery pins", pins(), P_WHI);
        @(negedge clk);
        chk("R9 idle after write", pins(), P_IDLE);
    endtask

    task automatic do_read(input logic [12:0] a, input logic [7:0] exp, input bit poke);
        issue(1'b0, a, 8'h5A);
        for (int i = 0; i < RD_N; i++) begin
            chk("R3 read pins", pins(), P_RD);
            chk("R8 read addr", mem_addr, a);
            if (poke && i == 2) begin
                req = 1'b1; req_we = 1'b1; req_addr = a ^ 13'h0040; req_wdata = 8'hC3;
            end else begin
                req = 1'b0;
            end
            @(negedge clk);
            req = 1'b0;
        end
        chk("R3 valid pulse", rd_valid, 1'b1);
        chk("R3 read byte", rd_data, exp);
        chk("R3 back to idle", pins(), P_IDLE);
        @(negedge clk);
        chk("R3 valid one cycle", rd_valid, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset pins", pins(), P_IDLE);
        chk("R1 reset valid", rd_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", pins(), P_IDLE);
    endtask

    task automatic t_basic();
        do_write(13'h0000, 8'h00);
        do_write(13'h1FFF, 8'hFF);
        do_write(13'h0AAA, 8'hA5);
        do_read(13'h1FFF, 8'hFF, 1'b0);
        do_read(13'h0000, 8'h00, 1'b0);
        do_read(13'h0AAA, 8'hA5, 1'b0);
    endtask

    // Request raised mid-read must leave its location untouched (R7).
    task automatic t_busy_ignored();
        do_write(13'h0123, 8'h3C);
        do_write(13'h0163, 8'h77);
        do_read(13'h0123, 8'h3C, 1'b1);
        chk("R7 idle after dropped req", pins(), P_IDLE);
        do_read(13'h0163, 8'h77, 1'b0);
    endtask

    // Write then read with no gap; the read begins one cycle after idle (R10, R9).
    task automatic t_back_to_back();
        do_write(13'h1555, 8'h96);
        chk("R10 ready after write", busy, 1'b0);
        chk("R9 drive released", mem_dq_oe, 1'b0);
        do_read(13'h1555, 8'h96, 1'b0);
        chk("R10 ready after read", busy, 1'b0);
        do_read(13'h1555, 8'h96, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_busy_ignored();
        t_back_to_back();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule